// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns one externally supplied word address into the address sequence of a short burst. A load strobe captures the full start address. After that, an advance enable steps the burst forward one beat per clock. Only the lowest address bits are generated inside the block. The bits above them keep the loaded value until the next load.

Two orderings are offered, selected by a static mode input:
- **Linear order** adds the beat number to the start offset and wraps inside the aligned group.
- **Interleaved order** combines the start offset with the beat number by exclusive-or.

When the advance enable is low, the address holds, which gives wait cycles in the middle of a burst. Deciding when to load or advance is left to the surrounding memory controller.

Top module: `burst_addr_gen`

## Requirements
- R1: During a clock edge with `rst_n` low, the block clears its state, and from the next cycle `addr_out` reads zero.
- R2: A clock edge with `load_en` high makes `addr_out` equal to `load_addr` in the following cycle, with the beat number restarted at zero.
- R3: Without a load, the bits of `addr_out` above the low `BEAT_W` bits never change; they keep the value last loaded.
- R4: With `mode_interleave` = 0 (linear), the low bits are (start offset + beat number) modulo 2^BEAT_W. For example, start 01 gives 01, 10, 11, 00, and start 11 gives 11, 00, 01, 10.
- R5: With `mode_interleave` = 1 (interleaved), the low bits are start offset XOR beat number. For example, start 01 gives 01, 00, 11, 10; start 10 gives 10, 11, 00, 01; start 11 gives 11, 10, 01, 00.
- R6: On an edge with `load_en` low and `advance_en` low, the beat number is held, so `addr_out` stays unchanged while the mode stays the same.
- R7: When `load_en` and `advance_en` are both high on the same edge, the load wins: the address becomes `load_addr` at beat zero.
- R8: After 2^BEAT_W advances without a load, the sequence wraps and `addr_out` returns to the loaded start address. It does not stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Capture `load_addr` as the new burst start |
| load_addr | input | ADDR_W | External start word address |
| advance_en | input | 1 | Step the burst by one beat |
| mode_interleave | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current word address of the burst |

## Verification
The bench builds the block with ADDR_W = 10 and the default BEAT_W = 2. A 10-bit address keeps the upper field small enough that random loads land on varied upper values, including all-ones. The four-beat group lets every start offset be combined with every beat number in both orderings within a few hundred cycles. Directed sequences cover the listed orders, wraparound after four advances, wait cycles, and a load colliding with an advance.

// File: rtl/burst_addr_pkg.sv
// Package burst_addr_pkg
// Shared types for the burst address sequencer.
// Assumes: the mode input is encoded as 0 = linear, 1 = interleaved.
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
// Module burst_base_reg
// Holds the start address of the current burst. It captures the external
// address on a load and clears it on reset.
// Assumes: the load strobe is already qualified by the controller.
module burst_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] base_q
);

    // Capture the start address on load; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_en) begin
            base_q <= load_addr;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Module burst_beat_ctr
// Beat number within the burst. A load restarts it at zero and an advance
// steps it by one, wrapping modulo 2^BEAT_W. Otherwise it holds.
// Assumes: the load has priority over the advance.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              advance_en,
    output logic [BEAT_W-1:0] beat_q
);

    // Restart on load, step on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_en) begin
            beat_q <= '0;
        end else if (advance_en) begin
            beat_q <= beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module burst_order_map
// Combines the start offset with the beat number into the low address bits.
// Linear order uses a modulo sum; interleaved order uses a bitwise XOR.
// Assumes: the mode is static during a burst. A change takes effect at once.
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] offset_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] xor_lo;

    // Linear order: modulo sum wraps inside the aligned group.
    always_comb lin_lo = start_lo + beat;

    // Interleaved order: one XOR per address bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        always_comb xor_lo[b] = start_lo[b] ^ beat[b];
    end

    // Select the ordering picked by the mode input.
    always_comb offset_lo = (order == ORD_XOR) ? xor_lo : lin_lo;

endmodule

// File: rtl/burst_addr_gen.sv
// Module burst_addr_gen (top)
// Burst address sequencer. The upper address bits come straight from the
// loaded start address. The low BEAT_W bits follow the selected burst order
// as the beat counter advances.
// Assumes: load and advance strobes come from the memory controller;
// mode_interleave is static.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance_en,
    input  logic              mode_interleave,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] offset_lo;
    burst_order_e      order;

    // Map the raw mode pin onto the ordering type.
    always_comb order = burst_order_e'(mode_interleave);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .base_q    (base_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .advance_en (advance_en),
        .beat_q     (beat_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_lo  (base_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order     (order),
        .offset_lo (offset_lo)
    );

    // Join the fixed upper field with the sequenced low bits.
    always_comb addr_out = {base_q[ADDR_W-1 -: UPPER_W], offset_lo};

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module burst_addr_gen_chk
// Port-level checker for burst_addr_gen, attached with bind.
// Assumes: synchronous active-low reset.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic              advance_en,
    input logic              mode_interleave,
    input logic [ADDR_W-1:0] addr_out
);

    // Set once a reset edge has defined the state.
    logic primed;

    // Record that at least one reset edge has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b1;
        else if (primed !== 1'b1) primed <= 1'b0;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (addr_out == $past(load_addr)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && advance_en) |=> (addr_out == $past(load_addr)));

    // R3
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !load_en) |=>
            (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !load_en && !advance_en) |=>
            ((mode_interleave != $past(mode_interleave)) || $stable(addr_out)));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !load_en && advance_en && !mode_interleave) |=>
            (mode_interleave ||
             (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1))));

    // R5
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !load_en && advance_en && mode_interleave) |=>
            (!mode_interleave ||
             ($countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) >= 1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .load_en         (load_en),
    .load_addr       (load_addr),
    .advance_en      (advance_en),
    .mode_interleave (mode_interleave),
    .addr_out        (addr_out)
);

// File: tb/sim_burst_addr_gen.sv
// Bench for burst_addr_gen: directed corner cases followed by seeded random
// stimulus, compared against a bench-side model of the requirements.
module sim_burst_addr_gen;

    localparam int ADDR_W = 10;
    localparam int BEAT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic [ADDR_W-1:0] load_addr = '0;
    logic              advance_en = 1'b0;
    logic              mode_interleave = 1'b0;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    logic [ADDR_W-1:0] m_start = '0;
    logic [BEAT_W-1:0] m_beat  = '0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_en         (load_en),
        .load_addr       (load_addr),
        .advance_en      (advance_en),
        .mode_interleave (mode_interleave),
        .addr_out        (addr_out)
    );

    // Expected address from the start, beat number and mode (R4, R5).
    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] st,
                                                   input logic [BEAT_W-1:0] bt,
                                                   input logic md);
        logic [BEAT_W-1:0] lo;
        lo = md ? (st[BEAT_W-1:0] ^ bt) : BEAT_W'(st[BEAT_W-1:0] + bt);
        return {st[ADDR_W-1:BEAT_W], lo};
    endfunction

    task automatic check(input string tag, input logic [ADDR_W-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, sample at the next falling edge.
    task automatic step(input logic ld, input logic [ADDR_W-1:0] la, input logic adv);
        load_en = ld; load_addr = la; advance_en = adv;
        @(posedge clk);
        if (!rst_n) begin
            m_start = '0; m_beat = '0;
        end else if (ld) begin
            m_start = la; m_beat = '0;
        end else if (adv) begin
            m_beat = m_beat + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic seq4(input string tag, input logic [ADDR_W-1:0] st,
                        input logic [BEAT_W-1:0] b0, input logic [BEAT_W-1:0] b1,
                        input logic [BEAT_W-1:0] b2, input logic [BEAT_W-1:0] b3);
        step(1'b1, st, 1'b0);
        check(tag, {st[ADDR_W-1:BEAT_W], b0});
        step(1'b0, '0, 1'b1);
        check(tag, {st[ADDR_W-1:BEAT_W], b1});
        step(1'b0, '0, 1'b1);
        check(tag, {st[ADDR_W-1:BEAT_W], b2});
        step(1'b0, '0, 1'b1);
        check(tag, {st[ADDR_W-1:BEAT_W], b3});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [ADDR_W-1:0] held;
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset clears the address.
        step(1'b1, 10'h3ff, 1'b1);
        check("R1", '0);
        rst_n = 1'b1;

        // R4: linear orders from two start offsets.
        mode_interleave = 1'b0;
        seq4("R4", 10'h2a1, 2'b01, 2'b10, 2'b11, 2'b00);
        seq4("R4", 10'h0c3, 2'b11, 2'b00, 2'b01, 2'b10);
        // R8: fourth advance wraps to the start.
        step(1'b0, '0, 1'b1);
        check("R8", 10'h0c3);

        // R5: interleaved orders.
        mode_interleave = 1'b1;
        seq4("R5", 10'h155, 2'b01, 2'b00, 2'b11, 2'b10);
        seq4("R5", 10'h3fe, 2'b10, 2'b11, 2'b00, 2'b01);
        seq4("R5", 10'h203, 2'b11, 2'b10, 2'b01, 2'b00);
        step(1'b0, '0, 1'b1);
        check("R8", 10'h203);

        // R6: wait cycles hold the address mid-burst.
        step(1'b0, '0, 1'b1);
        held = addr_out;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 10'h111, 1'b0);
            check("R6", held);
        end

        // R7: load colliding with an advance restarts at the new address.
        step(1'b1, 10'h2b6, 1'b1);
        check("R7", 10'h2b6);
        // R3: upper bits stay fixed across advances.
        step(1'b0, 10'h000, 1'b1);
        check("R3", {8'hAD, addr_out[1:0]});

        // Random phase against the model.
        for (int n = 0; n < 3000; n++) begin
            if (n % 250 == 0) mode_interleave = $urandom_range(0, 1);
            step(($urandom_range(0, 5) == 0), ADDR_W'($urandom), ($urandom_range(0, 2) != 0));
            check(mode_interleave ? "R5" : "R4", exp_addr(m_start, m_beat, mode_interleave));
        end

        // R1: reset in the middle of a burst.
        rst_n = 1'b0;
        step(1'b0, '0, 1'b1);
        check("R1", '0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule